// File: doc/BRIEF.md
# Configurable 4:2:2 Pixel Port Formatter

This block takes a 4:2:2 video stream as pixel pairs and places it on a 16-bit output data port. Each pair has two luma samples and one Cb and one Cr sample. The block runs from the full-rate pixel clock, and its output is a group of four clock cycles. A small phase state machine walks through the four cycles of each group: `PH_C0` (first chroma), `PH_Y0` (first luma), `PH_C1` (second chroma) and `PH_Y1` (second luma). The machine wraps from `PH_Y1` back to `PH_C0`, and no other transitions exist. Reset enters `PH_C0`.

During `PH_Y1` the block raises `pair_ack_o`. At the clock edge that ends `PH_Y1` it captures the next pixel pair and all of the control inputs. Those values then govern the whole of the next group. The control inputs are the format code, the chroma swap, the clock select and the clock polarity.

Three output modes exist:
- **Byte mode:** luma and chroma are interleaved on the low byte, one sample per clock. The high byte is three-stated.
- **Word mode:** luma sits on the high byte and chroma on the low byte, and each word is held for two clocks.
- **Off state:** unsupported format codes three-state the whole port and raise an error flag.

The output clock is either the pixel clock itself or a half-rate clock from a toggle flop. The half-rate clock is high during the luma cycles. Either clock can be inverted.

Top module: `pixport_fmt`

## Requirements
- R1: While reset is held, the state is `PH_C0` and byte mode is active. `port_data_o` is 0, `port_oe_o` is 2'b01 (bit 0 enables the low byte, bit 1 the high byte), `fmt_err_o` is 0, and `llc_o` follows the pixel clock.
- R2: In byte mode (format code 4'b0011), the four cycles of a group drive Cb, Y0, Cr, Y1 on `port_data_o[7:0]`. `port_data_o[15:8]` is 0 and `port_oe_o` is 2'b01.
- R3: When the swap bit is 1, the two chroma samples trade places. In byte mode the order becomes Cr, Y0, Cb, Y1.
- R4: In word mode (format code 4'b0010), the first two cycles drive {Y0, first chroma} and the last two drive {Y1, second chroma} on `port_data_o[15:8]`/`[7:0]`. `port_oe_o` is 2'b11. The first chroma is Cb, or Cr when swapped.
- R5: Every format code other than 4'b0011 and 4'b0010 gives `port_oe_o` = 2'b00, `port_data_o` = 0 and `fmt_err_o` = 1 for the whole group. This includes the reserved range 4'b0110 to 4'b1111.
- R6: The pixel pair and all control inputs are sampled only at the clock edge ending a cycle with `pair_ack_o` high. Changes at any other time have no effect on the group in progress.
- R7: `pair_ack_o` is high in the fourth cycle of each group and low in the other three. After reset is released, it is first high in the fourth cycle.
- R8: Any clock select code other than 3'b101 drives the pixel clock on `llc_o`, inverted when the polarity bit is 1.
- R9: Clock select 3'b101 drives a half-rate clock on `llc_o`. It is high for the whole of the `PH_Y0` and `PH_Y1` cycles and low in the chroma cycles, and the polarity bit inverts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 4 | Output format code |
| swap_cc | input | 1 | Exchange Cb and Cr order |
| clk_sel | input | 3 | Output clock select (3'b101 = half rate) |
| clk_inv | input | 1 | Invert output clock |
| y0_i | input | 8 | First luma sample of the pair |
| y1_i | input | 8 | Second luma sample of the pair |
| cb_i | input | 8 | Cb sample of the pair |
| cr_i | input | 8 | Cr sample of the pair |
| pair_ack_o | output | 1 | Pair and controls captured at end of this cycle |
| port_data_o | output | 16 | Output data port |
| port_oe_o | output | 2 | Per-byte output enable (bit 1 high byte) |
| fmt_err_o | output | 1 | Unsupported format code in effect |
| llc_o | output | 1 | Output line clock |

## Verification
A phase register that has slipped shows up within one group: luma appears in a chroma slot of the byte stream, `pair_ack_o` lands in the wrong cycle, and the half-rate clock goes high during a chroma cycle. A control register that loads outside the group boundary corrupts the very next output cycle, so the bench changes every input in the middle of a group. It then compares each of the four cycles against values computed from the settings that were captured. A toggle flop out of step with the phase machine is caught by the first half-rate clock sample.

// File: rtl/pixport_pkg.sv
package pixport_pkg;
    parameter int SW     = 8;
    parameter int LANES  = 2;
    parameter int FMT_W  = 4;
    parameter int CSEL_W = 3;
    localparam int PW    = LANES * SW;

    localparam logic [FMT_W-1:0]  FMT_BYTE  = 4'b0011;
    localparam logic [FMT_W-1:0]  FMT_WORD  = 4'b0010;
    localparam logic [CSEL_W-1:0] CSEL_HALF = 3'b101;

    typedef enum logic [1:0] {
        PH_C0 = 2'd0,
        PH_Y0 = 2'd1,
        PH_C1 = 2'd2,
        PH_Y1 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OM_BYTE = 2'd0,
        OM_WORD = 2'd1,
        OM_OFF  = 2'd2
    } omode_e;

    typedef struct packed {
        logic [SW-1:0] y0;
        logic [SW-1:0] y1;
        logic [SW-1:0] cb;
        logic [SW-1:0] cr;
    } pair_t;
endpackage

// File: rtl/pixport_phase_fsm.sv
module pixport_phase_fsm
    import pixport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FMT_W-1:0]  fmt_sel,
    input  logic              swap_i,
    input  logic [CSEL_W-1:0] clk_sel,
    input  logic              clk_inv,
    output phase_e            phase,
    output omode_e            mode_q,
    output logic              swap_q,
    output logic              half_q,
    output logic              inv_q,
    output logic              grp_end
);
    phase_e nxt;

    function automatic omode_e decode_fmt(input logic [FMT_W-1:0] code);
        if (code == FMT_BYTE)      return OM_BYTE;
        else if (code == FMT_WORD) return OM_WORD;
        else                       return OM_OFF;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_C0;
        else        phase <= nxt;
    end

    // next state and outputs
    always_comb begin
        unique case (phase)
            PH_C0: nxt = PH_Y0;
            PH_Y0: nxt = PH_C1;
            PH_C1: nxt = PH_Y1;
            PH_Y1: nxt = PH_C0;
        endcase
        grp_end = (phase == PH_Y1);
    end

    // controls captured only at the group boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= OM_BYTE;
            swap_q <= 1'b0;
            half_q <= 1'b0;
            inv_q  <= 1'b0;
        end else if (grp_end) begin
            mode_q <= decode_fmt(fmt_sel);
            swap_q <= swap_i;
            half_q <= (clk_sel == CSEL_HALF);
            inv_q  <= clk_inv;
        end
    end

    a_r7_wrap_to_c0: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end |=> (phase == PH_C0));

    a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_end |=> ($stable(mode_q) && $stable(swap_q) && $stable(half_q) && $stable(inv_q)));
endmodule

// File: rtl/pixport_half_clk.sv
module pixport_half_clk (
    input  logic clk,
    input  logic rst_n,
    output logic hclk_q
);
    // reset phase 0 so the chroma cycle that follows reset is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hclk_q <= 1'b0;
        else        hclk_q <= ~hclk_q;
    end
endmodule

// File: rtl/pixport_lane_mux.sv
module pixport_lane_mux
    import pixport_pkg::*;
(
    input  phase_e           phase,
    input  omode_e           mode,
    input  logic             swap,
    input  pair_t            pair,
    output logic [PW-1:0]    data,
    output logic [LANES-1:0] oe,
    output logic             err
);
    logic [SW-1:0] c_first;
    logic [SW-1:0] c_second;

    always_comb begin
        c_first  = swap ? pair.cr : pair.cb;
        c_second = swap ? pair.cb : pair.cr;
        data     = '0;
        oe       = '0;
        err      = 1'b0;
        unique case (mode)
            OM_BYTE: begin
                oe[0] = 1'b1;
                unique case (phase)
                    PH_C0: data[SW-1:0] = c_first;
                    PH_Y0: data[SW-1:0] = pair.y0;
                    PH_C1: data[SW-1:0] = c_second;
                    PH_Y1: data[SW-1:0] = pair.y1;
                endcase
            end
            OM_WORD: begin
                oe = '1;
                if (phase == PH_C0 || phase == PH_Y0) data = {pair.y0, c_first};
                else                                  data = {pair.y1, c_second};
            end
            default: err = 1'b1;
        endcase
    end
endmodule

// File: rtl/pixport_fmt.sv
module pixport_fmt
    import pixport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FMT_W-1:0]  fmt_sel,
    input  logic              swap_cc,
    input  logic [CSEL_W-1:0] clk_sel,
    input  logic              clk_inv,
    input  logic [SW-1:0]     y0_i,
    input  logic [SW-1:0]     y1_i,
    input  logic [SW-1:0]     cb_i,
    input  logic [SW-1:0]     cr_i,
    output logic              pair_ack_o,
    output logic [PW-1:0]     port_data_o,
    output logic [LANES-1:0]  port_oe_o,
    output logic              fmt_err_o,
    output logic              llc_o
);
    phase_e phase;
    omode_e mode_q;
    logic   swap_q;
    logic   half_q;
    logic   inv_q;
    logic   grp_end;
    logic   hclk_q;
    pair_t  pair_q;

    pixport_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_sel (fmt_sel),
        .swap_i  (swap_cc),
        .clk_sel (clk_sel),
        .clk_inv (clk_inv),
        .phase   (phase),
        .mode_q  (mode_q),
        .swap_q  (swap_q),
        .half_q  (half_q),
        .inv_q   (inv_q),
        .grp_end (grp_end)
    );

    pixport_half_clk u_hclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .hclk_q (hclk_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pair_q <= '0;
        else if (grp_end) pair_q <= '{y0: y0_i, y1: y1_i, cb: cb_i, cr: cr_i};
    end

    pixport_lane_mux u_mux (
        .phase (phase),
        .mode  (mode_q),
        .swap  (swap_q),
        .pair  (pair_q),
        .data  (port_data_o),
        .oe    (port_oe_o),
        .err   (fmt_err_o)
    );

    assign pair_ack_o = grp_end;
    assign llc_o      = (half_q ? hclk_q : clk) ^ inv_q;

    a_r9_hclk_phase: assert property (@(posedge clk) disable iff (!rst_n)
        hclk_q == (phase == PH_Y0 || phase == PH_Y1));

    a_r4_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OM_WORD && phase == PH_Y0) |-> $stable(port_data_o));
endmodule

// File: tb/pixport_fmt_test.sv
module pixport_fmt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fmt_sel = 4'b0011;
    logic        swap_cc = 1'b0;
    logic [2:0]  clk_sel = 3'b000;
    logic        clk_inv = 1'b0;
    logic [7:0]  y0_i = '0, y1_i = '0, cb_i = '0, cr_i = '0;
    logic        pair_ack_o;
    logic [15:0] port_data_o;
    logic [1:0]  port_oe_o;
    logic        fmt_err_o;
    logic        llc_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] data;
        logic [1:0]  oe;
        logic        err;
        logic        ack;
        logic        lhi;
        logic        llo;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    pixport_fmt uut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .swap_cc(swap_cc),
        .clk_sel(clk_sel), .clk_inv(clk_inv), .y0_i(y0_i), .y1_i(y1_i),
        .cb_i(cb_i), .cr_i(cr_i), .pair_ack_o(pair_ack_o),
        .port_data_o(port_data_o), .port_oe_o(port_oe_o),
        .fmt_err_o(fmt_err_o), .llc_o(llc_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: waits for the group boundary, drives inputs, pushes expectations
    task automatic run_group(input string tag,
                             input logic [7:0] y0, input logic [7:0] y1,
                             input logic [7:0] cb, input logic [7:0] cr,
                             input logic [3:0] f, input logic s,
                             input logic [2:0] cs, input logic inv,
                             input bit disturb);
        logic [7:0] ca, cbb;
        @(negedge clk);
        while (!pair_ack_o) @(negedge clk);
        fmt_sel = f; swap_cc = s; clk_sel = cs; clk_inv = inv;
        y0_i = y0; y1_i = y1; cb_i = cb; cr_i = cr;
        ca  = s ? cr : cb;
        cbb = s ? cb : cr;
        for (int p = 0; p < 4; p++) begin
            exp_t e;
            e.tag = tag;
            e.ack = (p == 3);
            if (f == 4'b0011) begin
                e.oe = 2'b01; e.err = 1'b0;
                case (p)
                    0: e.data = {8'h00, ca};
                    1: e.data = {8'h00, y0};
                    2: e.data = {8'h00, cbb};
                    default: e.data = {8'h00, y1};
                endcase
            end else if (f == 4'b0010) begin
                e.oe = 2'b11; e.err = 1'b0;
                e.data = (p < 2) ? {y0, ca} : {y1, cbb};
            end else begin
                e.oe = 2'b00; e.err = 1'b1; e.data = 16'h0000;
            end
            if (cs == 3'b101) begin
                e.lhi = (p % 2 == 1) ^ inv;
                e.llo = e.lhi;
            end else begin
                e.lhi = 1'b1 ^ inv;
                e.llo = inv;
            end
            q.push_back(e);
        end
        if (disturb) begin
            @(negedge clk);
            fmt_sel = (f == 4'b0011) ? 4'b0010 : 4'b0011;
            swap_cc = ~s;
            clk_sel = (cs == 3'b101) ? 3'b000 : 3'b101;
            clk_inv = ~inv;
            y0_i = ~y0; y1_i = ~y1; cb_i = ~cb; cr_i = ~cr;
        end
    endtask

    // monitor: pops one expectation per cycle once the queue is filled
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "data", port_data_o, e.data);
                check(e.tag, "oe", {14'h0, port_oe_o}, {14'h0, e.oe});
                check(e.tag, "err", {15'h0, fmt_err_o}, {15'h0, e.err});
                check({e.tag, "/R7"}, "ack", {15'h0, pair_ack_o}, {15'h0, e.ack});
                check(e.tag, "llc_hi", {15'h0, llc_o}, {15'h0, e.lhi});
                #4;
                check(e.tag, "llc_lo", {15'h0, llc_o}, {15'h0, e.llo});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: values while reset is held
        repeat (2) @(posedge clk);
        #3;
        check("R1", "data", port_data_o, 16'h0000);
        check("R1", "oe", {14'h0, port_oe_o}, 16'h0001);
        check("R1", "err", {15'h0, fmt_err_o}, 16'h0000);
        check("R1", "llc_hi", {15'h0, llc_o}, 16'h0001);
        #4;
        check("R1", "llc_lo", {15'h0, llc_o}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: first acknowledge in the fourth cycle after release
        check("R7", "ack_c0", {15'h0, pair_ack_o}, 16'h0000);
        @(negedge clk);
        check("R7", "ack_y0", {15'h0, pair_ack_o}, 16'h0000);
        @(negedge clk);
        check("R7", "ack_c1", {15'h0, pair_ack_o}, 16'h0000);

        run_group("R2_byte",      8'h33, 8'h44, 8'h11, 8'h22, 4'b0011, 1'b0, 3'b000, 1'b0, 0);
        run_group("R3_byte_swap", 8'hA3, 8'hB4, 8'hC1, 8'hD2, 4'b0011, 1'b1, 3'b000, 1'b0, 0);
        run_group("R4_word",      8'h5A, 8'h6B, 8'h7C, 8'h8D, 4'b0010, 1'b0, 3'b000, 1'b0, 0);
        run_group("R4_word_swap", 8'h01, 8'hFE, 8'h80, 8'h7F, 4'b0010, 1'b1, 3'b000, 1'b0, 0);
        run_group("R5_rsv0111",   8'h12, 8'h34, 8'h56, 8'h78, 4'b0111, 1'b0, 3'b000, 1'b0, 0);
        run_group("R5_rsv1111",   8'h9A, 8'hBC, 8'hDE, 8'hF0, 4'b1111, 1'b1, 3'b000, 1'b0, 0);
        run_group("R5_code0000",  8'h21, 8'h43, 8'h65, 8'h87, 4'b0000, 1'b0, 3'b000, 1'b0, 0);
        run_group("R2_after_err", 8'hE1, 8'hE2, 8'hE3, 8'hE4, 4'b0011, 1'b0, 3'b000, 1'b0, 0);
        run_group("R6_byte_dist", 8'h0F, 8'hF0, 8'h3C, 8'hC3, 4'b0011, 1'b0, 3'b000, 1'b0, 1);
        run_group("R6_word_dist", 8'h55, 8'hAA, 8'h66, 8'h99, 4'b0010, 1'b1, 3'b101, 1'b1, 1);
        run_group("R9_half",      8'h10, 8'h20, 8'h30, 8'h40, 4'b0010, 1'b0, 3'b101, 1'b0, 0);
        run_group("R9_half_inv",  8'h11, 8'h21, 8'h31, 8'h41, 4'b0011, 1'b0, 3'b101, 1'b1, 0);
        run_group("R8_full_inv",  8'h12, 8'h22, 8'h32, 8'h42, 4'b0011, 1'b1, 3'b000, 1'b1, 0);
        run_group("R8_sel011",    8'h13, 8'h23, 8'h33, 8'h43, 4'b0010, 1'b0, 3'b011, 1'b0, 0);
        run_group("R2_final",     8'h14, 8'h24, 8'h34, 8'h44, 4'b0011, 1'b0, 3'b000, 1'b0, 0);

        wait (q.size() == 0);
        @(posedge clk);
        #8;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule